// File: doc/BRIEF.md
# Register Window Counter Manager

This block holds the bookkeeping state of a windowed integer register file. The state is a current-window pointer and four occupancy counters: windows free for a save, windows holding caller data that a restore can reload, windows that belong to another address space, and windows already scrubbed. The register storage and the spill and fill trap logic sit elsewhere. A spill or fill handler tells the block when it has finished moving one window out ("saved") or back in ("restored"). Privileged software writes and reads each counter directly through a single selector port.

A saved or restored event moves the occupancy counters in pairs. When the other-space count is nonzero, that count is used up before the count on the normal side. The scrubbed count rises on each restore but never goes past the number of windows. A direct write whose value is out of range is refused and reported. A saved event that arrives while save room is still left raises a warning. Saved and restored events in the same cycle are refused as a conflict. All three flags are one-cycle pulses in the cycle after the event that caused them. The number of windows, `NWIN`, is a parameter, and every counter is `$clog2(NWIN+1)` bits wide.

Top module: `winctl_top`

## Requirements
- R1: After reset the pointer, can-restore and other-windows read 0, can-save reads NWIN-2, clean-windows reads NWIN, and all three flags are low.
- R2: A lone saved event (no restored event, no write) adds one to can-save. If other-windows is zero it takes one from can-restore; otherwise it takes one from other-windows. The result appears on the next cycle.
- R3: A lone restored event adds one to can-restore. If other-windows is zero it takes one from can-save; otherwise it takes one from other-windows. The pointer is never changed by an event.
- R4: A lone restored event adds one to clean-windows unless clean-windows already equals NWIN, in which case it stays at NWIN.
- R5: Selector codes are 0 = pointer, 1 = can-save, 2 = can-restore, 3 = other-windows, 4 = clean-windows. `rd_val` shows the field chosen by `rd_sel` combinationally. A legal write replaces the chosen field on the next clock.
- R6: A write above NWIN-1 to codes 0 to 3, or above NWIN to code 4, leaves the field unchanged and pulses `err_illegal` for one cycle after the write.
- R7: A lone saved event that arrives while can-save is nonzero pulses `warn_busy` for one cycle after the event.
- R8: Saved and restored events asserted in the same cycle pulse `err_conflict` for one cycle after, and change no counter.
- R9: When `wr_en` is high, any saved or restored event in that cycle is dropped. Only the write acts, although a simultaneous pair still raises `err_conflict`.
- R10: Counter arithmetic wraps modulo 2^W. Selector codes 5 to 7 read as zero, and writes to them change nothing and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_saved | input | 1 | Spill handler finished one window |
| ev_restored | input | 1 | Fill handler finished one window |
| wr_en | input | 1 | Direct write strobe |
| wr_sel | input | 3 | Field written (R5 encoding) |
| wr_val | input | W | Value written |
| rd_sel | input | 3 | Field read (R5 encoding) |
| rd_val | output | W | Value of the selected field |
| err_illegal | output | 1 | Out-of-range write refused |
| err_conflict | output | 1 | Saved and restored together |
| warn_busy | output | 1 | Saved event while can-save nonzero |

## Verification
A wrong counter update shows on `rd_val` in the first cycle after the event once the read selector points at that field. The bench sweeps the selector across all codes, so a bad field is seen within a few cycles. A wrong choice between other-windows and the normal counter only shows once other-windows is nonzero, so the directed phase loads it before issuing events. A flag driven from the wrong cycle or the wrong condition shows as a pulse offset by one cycle. Saturation and range errors are pushed to their exact boundaries at NWIN-1, NWIN and NWIN+1.

// File: rtl/winctl_pkg.sv
package winctl_pkg;
    localparam int SEL_W = 3;
    localparam int NSEL  = 2 ** SEL_W;
    localparam int NFLD  = 5;

    typedef enum logic [SEL_W-1:0] {
        SEL_PTR   = 3'd0,
        SEL_CSAVE = 3'd1,
        SEL_CREST = 3'd2,
        SEL_OTHER = 3'd3,
        SEL_CLEAN = 3'd4
    } win_sel_e;
endpackage

// File: rtl/winctl_lim.sv
module winctl_lim #(
    parameter int W     = 4,
    parameter int LIMIT = 7
) (
    input  logic [W-1:0] val,
    output logic         ok
);
    localparam logic [W:0] LIM_V = (W+1)'(LIMIT);
    assign ok = ({1'b0, val} <= LIM_V);
endmodule

// File: rtl/winctl_evupd.sv
module winctl_evupd #(
    parameter int W    = 4,
    parameter int NWIN = 8
) (
    input  logic [W-1:0] csave,
    input  logic [W-1:0] crest,
    input  logic [W-1:0] other,
    input  logic [W-1:0] clean,
    input  logic         do_save,
    input  logic         do_rest,
    output logic [W-1:0] csave_n,
    output logic [W-1:0] crest_n,
    output logic [W-1:0] other_n,
    output logic [W-1:0] clean_n
);
    localparam logic [W-1:0] ONE   = W'(1);
    localparam logic [W-1:0] FULL  = W'(NWIN);

    logic other_zero;
    assign other_zero = (other == '0);

    always_comb begin
        csave_n = csave;
        crest_n = crest;
        other_n = other;
        clean_n = clean;
        if (do_save) begin
            csave_n = csave + ONE;
            if (other_zero) crest_n = crest - ONE;
            else            other_n = other - ONE;
        end else if (do_rest) begin
            crest_n = crest + ONE;
            if (other_zero) csave_n = csave - ONE;
            else            other_n = other - ONE;
            if (clean != FULL) clean_n = clean + ONE;
        end
    end
endmodule

// File: rtl/winctl_rdmux.sv
module winctl_rdmux #(
    parameter int W  = 4,
    parameter int SW = 3
) (
    input  logic [W-1:0]  flds [2**SW],
    input  logic [SW-1:0] sel,
    output logic [W-1:0]  val
);
    assign val = flds[sel];
endmodule

// File: rtl/winctl_top.sv
module winctl_top
    import winctl_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int W   = $clog2(NWIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_saved,
    input  logic             ev_restored,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_val,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [W-1:0]     rd_val,
    output logic             err_illegal,
    output logic             err_conflict,
    output logic             warn_busy
);
    typedef struct packed {
        logic [W-1:0] cwp;
        logic [W-1:0] csave;
        logic [W-1:0] crest;
        logic [W-1:0] other;
        logic [W-1:0] clean;
        logic         e_ill;
        logic         e_conf;
        logic         warn;
    } win_st_t;

    localparam win_st_t RST_ST = '{
        cwp:   '0,
        csave: W'(NWIN - 2),
        crest: '0,
        other: '0,
        clean: W'(NWIN),
        e_ill: 1'b0,
        e_conf: 1'b0,
        warn:  1'b0
    };

    win_st_t st_d, st_q;

    // per-selector view of the state and the write range check
    logic [W-1:0]    fld_q [NSEL];
    logic [NSEL-1:0] lim_ok;

    assign fld_q[SEL_PTR]   = st_q.cwp;
    assign fld_q[SEL_CSAVE] = st_q.csave;
    assign fld_q[SEL_CREST] = st_q.crest;
    assign fld_q[SEL_OTHER] = st_q.other;
    assign fld_q[SEL_CLEAN] = st_q.clean;

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        if (i >= NFLD) begin : g_unused
            assign fld_q[i]  = '0;
            assign lim_ok[i] = 1'b0;
        end else begin : g_lim
            winctl_lim #(
                .W     (W),
                .LIMIT ((i == int'(SEL_CLEAN)) ? NWIN : NWIN - 1)
            ) u_lim (
                .val (wr_val),
                .ok  (lim_ok[i])
            );
        end
    end

    winctl_rdmux #(.W(W), .SW(SEL_W)) u_rd (
        .flds (fld_q),
        .sel  (rd_sel),
        .val  (rd_val)
    );

    // event path: only a lone event with no write reaches the counters
    logic         both_ev, do_save, do_rest;
    logic [W-1:0] cs_n, cr_n, ow_n, cl_n;

    assign both_ev = ev_saved & ev_restored;
    assign do_save = ev_saved    & ~ev_restored & ~wr_en;
    assign do_rest = ev_restored & ~ev_saved    & ~wr_en;

    winctl_evupd #(.W(W), .NWIN(NWIN)) u_ev (
        .csave   (st_q.csave),
        .crest   (st_q.crest),
        .other   (st_q.other),
        .clean   (st_q.clean),
        .do_save (do_save),
        .do_rest (do_rest),
        .csave_n (cs_n),
        .crest_n (cr_n),
        .other_n (ow_n),
        .clean_n (cl_n)
    );

    always_comb begin
        st_d        = st_q;
        st_d.e_ill  = 1'b0;
        st_d.e_conf = both_ev;
        st_d.warn   = do_save & (st_q.csave != '0);
        if (wr_en) begin
            if (int'(wr_sel) < NFLD) begin
                if (lim_ok[wr_sel]) begin
                    case (win_sel_e'(wr_sel))
                        SEL_PTR:   st_d.cwp   = wr_val;
                        SEL_CSAVE: st_d.csave = wr_val;
                        SEL_CREST: st_d.crest = wr_val;
                        SEL_OTHER: st_d.other = wr_val;
                        SEL_CLEAN: st_d.clean = wr_val;
                        default:   st_d.cwp   = st_q.cwp;
                    endcase
                end else begin
                    st_d.e_ill = 1'b1;
                end
            end
        end else begin
            st_d.csave = cs_n;
            st_d.crest = cr_n;
            st_d.other = ow_n;
            st_d.clean = cl_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign err_illegal  = st_q.e_ill;
    assign err_conflict = st_q.e_conf;
    assign warn_busy    = st_q.warn;
endmodule

// File: rtl/winctl_chk.sv
module winctl_chk #(
    parameter int NWIN = 8,
    localparam int W   = $clog2(NWIN + 1)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ev_saved,
    input logic         ev_restored,
    input logic         wr_en,
    input logic [2:0]   wr_sel,
    input logic [W-1:0] wr_val,
    input logic [W-1:0] cwp_q,
    input logic [W-1:0] cs_q,
    input logic [W-1:0] cr_q,
    input logic [W-1:0] cl_q,
    input logic         err_illegal,
    input logic         err_conflict
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] FULL = W'(NWIN);

    AST_SAVED_BUMPS_CSAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_saved && !ev_restored && !wr_en) |=> (cs_q == $past(cs_q) + ONE)); // R2

    AST_RESTORED_BUMPS_CREST: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_restored && !ev_saved && !wr_en) |=> (cr_q == $past(cr_q) + ONE)); // R3

    AST_POINTER_IGNORES_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cwp_q)); // R3

    AST_CLEAN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        cl_q <= FULL); // R4

    AST_ILLEGAL_CSAVE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd1 && wr_val > W'(NWIN - 1)) |=> (err_illegal && $stable(cs_q))); // R6

    AST_CONFLICT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_saved && ev_restored && !wr_en) |=> (err_conflict && $stable(cs_q) && $stable(cr_q) && $stable(cl_q))); // R8
endmodule

bind winctl_top winctl_chk #(.NWIN(NWIN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_saved     (ev_saved),
    .ev_restored  (ev_restored),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_val       (wr_val),
    .cwp_q        (st_q.cwp),
    .cs_q         (st_q.csave),
    .cr_q         (st_q.crest),
    .cl_q         (st_q.clean),
    .err_illegal  (err_illegal),
    .err_conflict (err_conflict)
);

// File: tb/tb_winctl_top.sv
`timescale 1ns/1ps
module tb_winctl_top;
    localparam int NWIN = 8;
    localparam int W    = $clog2(NWIN + 1);
    localparam int M    = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ev_saved = 1'b0, ev_restored = 1'b0, wr_en = 1'b0;
    logic [2:0]   wr_sel = '0, rd_sel = '0;
    logic [W-1:0] wr_val = '0;
    logic [W-1:0] rd_val;
    logic         err_illegal, err_conflict, warn_busy;

    always #2 clk = ~clk;

    winctl_top #(.NWIN(NWIN)) dut (
        .clk, .rst_n, .ev_saved, .ev_restored, .wr_en, .wr_sel,
        .wr_val, .rd_sel, .rd_val, .err_illegal, .err_conflict, .warn_busy
    );

    // behavioural model: 0 ptr, 1 can-save, 2 can-restore, 3 other, 4 clean
    int fld [5];
    int m_ill, m_conf, m_warn;
    int vectors = 0, fails = 0;

    task automatic model_reset();
        fld[0] = 0; fld[1] = NWIN - 2; fld[2] = 0; fld[3] = 0; fld[4] = NWIN;
        m_ill = 0; m_conf = 0; m_warn = 0;
    endtask

    task automatic model_step(int s, int r, int we, int ws, int wv);
        m_ill = 0; m_warn = 0;
        m_conf = (s != 0 && r != 0) ? 1 : 0;
        if (we != 0) begin
            if (ws < 5) begin
                if (wv <= ((ws == 4) ? NWIN : NWIN - 1)) fld[ws] = wv;
                else m_ill = 1;
            end
        end else if (s != 0 && r == 0) begin
            m_warn = (fld[1] != 0) ? 1 : 0;
            fld[1] = (fld[1] + 1) & M;
            if (fld[3] == 0) fld[2] = (fld[2] - 1) & M;
            else             fld[3] = (fld[3] - 1) & M;
        end else if (r != 0 && s == 0) begin
            fld[2] = (fld[2] + 1) & M;
            if (fld[3] == 0) fld[1] = (fld[1] - 1) & M;
            else             fld[3] = (fld[3] - 1) & M;
            if (fld[4] != NWIN) fld[4] = fld[4] + 1;
        end
    endtask

    task automatic compare(string req);
        int exp_rd;
        exp_rd = (int'(rd_sel) < 5) ? fld[rd_sel] : 0;
        vectors++;
        if (int'(rd_val) != exp_rd || int'(err_illegal) != m_ill ||
            int'(err_conflict) != m_conf || int'(warn_busy) != m_warn) begin
            fails++;
            $display("FAIL %s sel=%0d rd=%0d/%0d ill=%0d/%0d conf=%0d/%0d warn=%0d/%0d (actual/expected)",
                     req, rd_sel, rd_val, exp_rd, err_illegal, m_ill,
                     err_conflict, m_conf, warn_busy, m_warn);
        end
    endtask

    task automatic step(string req, int s, int r, int we, int ws, int wv, int rs);
        @(negedge clk);
        ev_saved = s[0]; ev_restored = r[0]; wr_en = we[0];
        wr_sel = 3'(ws); wr_val = W'(wv); rd_sel = 3'(rs);
        #1;
        compare(req);
        model_step(s, r, we, ws, wv);
    endtask

    task automatic idle_sweep(string req);
        for (int k = 0; k < 8; k++) step(req, 0, 0, 0, 0, 0, k);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_sweep("R1");                       // R1 reset values
        step("R5", 0, 0, 1, 3, 2, 3);           // R5 other-windows = 2
        step("R5", 0, 0, 1, 2, 3, 2);           // R5 can-restore = 3
        idle_sweep("R5");
        step("R2", 1, 0, 0, 0, 0, 3);           // R2 other used first, R7 warn
        step("R2", 1, 0, 0, 0, 0, 1);
        step("R2", 1, 0, 0, 0, 0, 2);           // R2 other now zero
        idle_sweep("R2");
        step("R5", 0, 0, 1, 3, 1, 3);
        step("R3", 0, 1, 0, 0, 0, 3);           // R3 other consumed
        step("R3", 0, 1, 0, 0, 0, 1);           // R3 can-save drops
        idle_sweep("R3");
        step("R4", 0, 0, 1, 4, NWIN - 1, 4);
        step("R4", 0, 1, 0, 0, 0, 4);           // R4 reaches NWIN
        step("R4", 0, 1, 0, 0, 0, 4);           // R4 stays at NWIN
        idle_sweep("R4");
        step("R6", 0, 0, 1, 1, NWIN, 1);        // R6 can-save over limit
        step("R6", 0, 0, 1, 4, NWIN + 1, 4);    // R6 clean over limit
        step("R6", 0, 0, 1, 4, NWIN, 4);        // R6 clean at limit ok
        step("R6", 0, 0, 1, 0, NWIN - 1, 0);    // R6 pointer at limit ok
        step("R6", 0, 0, 1, 0, NWIN, 0);        // R6 pointer over limit
        idle_sweep("R6");
        step("R7", 0, 0, 1, 1, 0, 1);
        step("R7", 1, 0, 0, 0, 0, 1);           // R7 no warn, can-save was 0
        step("R7", 1, 0, 0, 0, 0, 1);           // R7 warn, can-save was 1
        idle_sweep("R7");
        step("R8", 1, 1, 0, 0, 0, 1);           // R8 conflict
        idle_sweep("R8");
        step("R9", 1, 0, 1, 2, 5, 2);           // R9 write wins
        step("R9", 0, 1, 1, 1, 4, 1);
        step("R9", 1, 1, 1, 3, 1, 3);           // R9 write plus conflict
        idle_sweep("R9");
        step("R10", 0, 0, 1, 6, 3, 6);          // R10 unused selector
        step("R10", 0, 0, 1, 7, 15, 7);
        step("R10", 0, 0, 1, 2, 0, 2);
        step("R10", 0, 0, 1, 3, 0, 2);
        step("R10", 1, 0, 0, 0, 0, 2);          // R10 can-restore wraps to M
        idle_sweep("R10");
        for (int n = 0; n < 4000; n++) begin
            int s, r, we;
            s  = ($urandom % 10) < 3 ? 1 : 0;
            r  = ($urandom % 10) < 3 ? 1 : 0;
            we = ($urandom % 10) < 2 ? 1 : 0;
            step("R2/R3 random", s, r, we, int'($urandom % 8), int'($urandom % (M + 1)),
                 int'($urandom % 8));
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule